// File: doc/BRIEF.md
# Nibble-Written 2K Window Bank Mapper

This block is the bank controller of a cartridge. It keeps eight 8-bit bank registers, each loaded in two 4-bit halves by CPU writes to a scattered set of addresses in the 0xB000-0xE003 range. CPU reads in 0x6000-0x9FFF fall into eight 2 KB windows, and each window is translated through its own register into a program ROM address. The 0xA000-0xBFFF range always reads one fixed 8 KB bank, and 0xC000-0xFFFF always reads one fixed 16 KB bank. A write anywhere in 0x8000-0x9FFF also selects the nametable mirroring.

The translated address is registered. It appears one clock after the read strobe, marked by a valid pulse. Every ROM address is reduced modulo the configured ROM size by dropping the upper bits. Mirroring is a single level output. ROM contents are outside the block.

Top module: `nib_bank_mapper`

## Requirements
- R1: While reset is asserted and after it is released, every bank register is 0x00, `mirror_vert` is 0 and `rom_vld` is 0.
- R2: A write with `cpu_addr[0]`=0 to a register address replaces bits 3:0 of the selected register with `cpu_data[3:0]`. Bits 7:4 keep their value.
- R3: A write with `cpu_addr[0]`=1 to a register address replaces bits 7:4 of the selected register with `cpu_data[3:0]`. Bits 3:0 keep their value, and `cpu_data[7:4]` is ignored.
- R4: A write in 0xB000-0xE003 selects a register from `cpu_addr[15:12]` and `cpu_addr[1]`: 0xB gives 4 (addr[1]=0) or 5 (addr[1]=1); 0xC gives 6 or 7; 0xD gives 0 or 1; 0xE gives 2 or 3. Bits 11:2 of the address are ignored, so those addresses alias.
- R5: A read in 0x6000-0x9FFF uses window k = (addr - 0x6000) / 0x800, with k from 0 to 7, and register k. The result is `rom_addr` = reg[k]*0x800 + addr[10:0].
- R6: A read in 0xA000-0xBFFF gives `rom_addr` = FIX8_BANK*0x2000 + addr[12:0], with FIX8_BANK = 13 by default.
- R7: A read in 0xC000-0xFFFF gives `rom_addr` = FIX16_BANK*0x4000 + addr[13:0], with FIX16_BANK = 7 by default.
- R8: A write in 0x8000-0x9FFF sets `mirror_vert` to `cpu_data[0]`, where 1 means vertical and 0 means horizontal. The level holds until the next such write.
- R9: Writes outside 0x8000-0x9FFF and 0xB000-0xE003 are ignored. Examples are 0x6000, 0xA003, 0xE004 and 0xF000. Such writes change no bank register and do not change `mirror_vert`.
- R10: `rom_vld` is high in the cycle after a clock edge that samples `cpu_rd`=1 with `cpu_addr` >= 0x6000, and low otherwise. `rom_addr` changes only on those edges. A read below 0x6000 yields no pulse and leaves `rom_addr` unchanged.
- R11: If `cpu_rd` and `cpu_wr` are both high in one cycle, both take effect. The read is translated with the register values from before that edge, and the write is applied at that edge.
- R12: Every `rom_addr` is reduced modulo 2^ROM_AW (17 bits by default). For example, register 0xFF read at 0x9FFF gives 0x1FFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | BANK_W | CPU write data |
| cpu_rd | input | 1 | Read strobe, sampled on the rising edge |
| cpu_wr | input | 1 | Write strobe, sampled on the rising edge |
| rom_addr | output | ROM_AW | Translated program ROM byte address |
| rom_vld | output | 1 | `rom_addr` was updated by the previous edge |
| mirror_vert | output | 1 | 1 = vertical mirroring, 0 = horizontal |

## Verification
The block has a single address bus, so a read translation and a write can only fall in the same cycle for an address that is both readable and writable. Two such cases are provoked by raising `cpu_rd` and `cpu_wr` together. The first is an access at 0x8800: it reads through window 5 and also loads the mirroring bit. The second is an access at 0xD003: it reads the fixed 16 KB bank and also writes the high nibble of register 1. For each case the scoreboard checks that the translated address uses the pre-write state. A direct check confirms the mirroring level, and a later window read confirms the register now holds the new nibble.

// File: rtl/nbm_pkg.sv
package nbm_pkg;

    localparam int NUM_BANKS = 8;
    localparam int SEL_W     = $clog2(NUM_BANKS);
    localparam int WIN_AW    = 11;   // 2 KB windows
    localparam int FIX8_AW   = 13;   // 8 KB fixed bank
    localparam int FIX16_AW  = 14;   // 16 KB fixed bank
    localparam int LIN_W     = 32;

    typedef enum logic [1:0] {
        RGN_NONE,
        RGN_WINDOW,
        RGN_FIXED8,
        RGN_FIXED16
    } region_e;

    function automatic region_e classify(input logic [15:0] a);
        region_e r;
        if (a >= 16'hC000)      r = RGN_FIXED16;
        else if (a >= 16'hA000) r = RGN_FIXED8;
        else if (a >= 16'h6000) r = RGN_WINDOW;
        else                    r = RGN_NONE;
        return r;
    endfunction

    // 0x6000 >> 11 = 0xC, so subtracting 0xC modulo 8 equals flipping bit 2
    function automatic logic [SEL_W-1:0] window_sel(input logic [15:0] a);
        return a[WIN_AW+SEL_W-1:WIN_AW] ^ 3'b100;
    endfunction

    function automatic logic reg_write_hit(input logic [15:0] a);
        return (a >= 16'hB000) && (a <= 16'hE003);
    endfunction

    // upper address nibble B,C,D,E -> pair 2,3,0,1 ; addr[1] picks one of the pair
    function automatic logic [SEL_W-1:0] reg_write_sel(input logic [15:0] a);
        logic [3:0] pair;
        pair = a[15:12] - 4'hD;
        return {pair[1:0], a[1]};
    endfunction

endpackage

// File: rtl/nbm_wr_decode.sv
module nbm_wr_decode
    import nbm_pkg::*;
(
    input  logic                 cpu_wr,
    input  logic [15:0]          cpu_addr,
    output logic [NUM_BANKS-1:0] lo_we,
    output logic [NUM_BANKS-1:0] hi_we,
    output logic                 mirror_we
);

    logic             hit;
    logic [SEL_W-1:0] sel;

    assign hit       = cpu_wr && reg_write_hit(cpu_addr);
    assign sel       = reg_write_sel(cpu_addr);
    assign mirror_we = cpu_wr && (cpu_addr[15:13] == 3'b100);

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_we
        assign lo_we[k] = hit && (sel == SEL_W'(k)) && !cpu_addr[0];
        assign hi_we[k] = hit && (sel == SEL_W'(k)) &&  cpu_addr[0];
    end

endmodule

// File: rtl/nbm_bank_regs.sv
module nbm_bank_regs
    import nbm_pkg::*;
#(
    parameter int BANK_W = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_BANKS-1:0]              lo_we,
    input  logic [NUM_BANKS-1:0]              hi_we,
    input  logic [BANK_W/2-1:0]               nib,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]  bank_q
);

    localparam int NIB_W = BANK_W / 2;

    for (genvar k = 0; k < NUM_BANKS; k++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[k] <= '0;
            end else if (lo_we[k]) begin
                bank_q[k][NIB_W-1:0] <= nib;
            end else if (hi_we[k]) begin
                bank_q[k][BANK_W-1:NIB_W] <= nib;
            end
        end
    end

endmodule

// File: rtl/nbm_xlate.sv
module nbm_xlate
    import nbm_pkg::*;
#(
    parameter int ROM_AW     = 17,
    parameter int BANK_W     = 8,
    parameter int FIX8_BANK  = 13,
    parameter int FIX16_BANK = 7
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cpu_rd,
    input  logic [15:0]                       cpu_addr,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0]  bank_q,
    output logic [ROM_AW-1:0]                 rom_addr,
    output logic                              rom_vld
);

    localparam logic [LIN_W-1:0] FIX8_BASE  = LIN_W'(FIX8_BANK)  << FIX8_AW;
    localparam logic [LIN_W-1:0] FIX16_BASE = LIN_W'(FIX16_BANK) << FIX16_AW;

    region_e           rgn;
    logic [LIN_W-1:0]  lin;
    logic              take;

    assign rgn  = classify(cpu_addr);
    assign take = cpu_rd && (rgn != RGN_NONE);

    always_comb begin
        unique case (rgn)
            RGN_WINDOW:  lin = (LIN_W'(bank_q[window_sel(cpu_addr)]) << WIN_AW)
                               | LIN_W'(cpu_addr[WIN_AW-1:0]);
            RGN_FIXED8:  lin = FIX8_BASE  | LIN_W'(cpu_addr[FIX8_AW-1:0]);
            RGN_FIXED16: lin = FIX16_BASE | LIN_W'(cpu_addr[FIX16_AW-1:0]);
            default:     lin = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rom_addr <= '0;
            rom_vld  <= 1'b0;
        end else begin
            rom_vld <= take;
            if (take) rom_addr <= lin[ROM_AW-1:0];
        end
    end

endmodule

// File: rtl/nib_bank_mapper.sv
module nib_bank_mapper
    import nbm_pkg::*;
#(
    parameter int ROM_AW     = 17,
    parameter int BANK_W     = 8,
    parameter int FIX8_BANK  = 13,
    parameter int FIX16_BANK = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [15:0]        cpu_addr,
    input  logic [BANK_W-1:0]  cpu_data,
    input  logic               cpu_rd,
    input  logic               cpu_wr,
    output logic [ROM_AW-1:0]  rom_addr,
    output logic               rom_vld,
    output logic               mirror_vert
);

    localparam int NIB_W = BANK_W / 2;

    logic [NUM_BANKS-1:0]             lo_we;
    logic [NUM_BANKS-1:0]             hi_we;
    logic                             mirror_we;
    logic [NUM_BANKS-1:0][BANK_W-1:0] bank_q;

    nbm_wr_decode u_dec (
        .cpu_wr    (cpu_wr),
        .cpu_addr  (cpu_addr),
        .lo_we     (lo_we),
        .hi_we     (hi_we),
        .mirror_we (mirror_we)
    );

    nbm_bank_regs #(.BANK_W(BANK_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .lo_we  (lo_we),
        .hi_we  (hi_we),
        .nib    (cpu_data[NIB_W-1:0]),
        .bank_q (bank_q)
    );

    nbm_xlate #(
        .ROM_AW     (ROM_AW),
        .BANK_W     (BANK_W),
        .FIX8_BANK  (FIX8_BANK),
        .FIX16_BANK (FIX16_BANK)
    ) u_xlate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_rd   (cpu_rd),
        .cpu_addr (cpu_addr),
        .bank_q   (bank_q),
        .rom_addr (rom_addr),
        .rom_vld  (rom_vld)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mirror_vert <= 1'b0;
        else if (mirror_we) mirror_vert <= cpu_data[0];
    end

endmodule

// File: rtl/nbm_checker.sv
module nbm_checker #(
    parameter int ROM_AW     = 17,
    parameter int BANK_W     = 8,
    parameter int FIX8_BANK  = 13,
    parameter int FIX16_BANK = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [15:0]        cpu_addr,
    input logic [BANK_W-1:0]  cpu_data,
    input logic               cpu_rd,
    input logic               cpu_wr,
    input logic [ROM_AW-1:0]  rom_addr,
    input logic               rom_vld,
    input logic               mirror_vert
);

    logic        rd_hit;
    logic        mir_hit;
    logic [31:0] exp8;
    logic [31:0] exp16;

    assign rd_hit  = cpu_rd && (cpu_addr >= 16'h6000);
    assign mir_hit = cpu_wr && (cpu_addr >= 16'h8000) && (cpu_addr < 16'hA000);
    assign exp8    = FIX8_BANK  * 32'h2000 + 32'(cpu_addr % 16'h2000);
    assign exp16   = FIX16_BANK * 32'h4000 + 32'(cpu_addr % 16'h4000);

    a_r10_vld_after_rd: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> rom_vld);
    a_r10_no_vld_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> !rom_vld);
    a_r10_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> $stable(rom_addr));
    a_r8_mirror_load: assert property (@(posedge clk) disable iff (!rst_n)
        mir_hit |=> (mirror_vert == $past(cpu_data[0])));
    a_r9_mirror_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mir_hit |=> $stable(mirror_vert));
    a_r6_fixed8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= 16'hA000 && cpu_addr < 16'hC000)
        |=> (rom_addr == $past(exp8[ROM_AW-1:0])));
    a_r7_fixed16: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_addr >= 16'hC000)
        |=> (rom_addr == $past(exp16[ROM_AW-1:0])));

endmodule

bind nib_bank_mapper nbm_checker #(
    .ROM_AW     (ROM_AW),
    .BANK_W     (BANK_W),
    .FIX8_BANK  (FIX8_BANK),
    .FIX16_BANK (FIX16_BANK)
) u_nbm_checker (.*);

// File: tb/nib_bank_mapper_bench.sv
module nib_bank_mapper_bench;

    localparam int ROM_AW = 17;
    localparam int MASK   = (1 << ROM_AW) - 1;

    typedef struct {
        int    exp;
        string tag;
    } sb_item_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [15:0]       cpu_addr = '0;
    logic [7:0]        cpu_data = '0;
    logic              cpu_rd = 1'b0;
    logic              cpu_wr = 1'b0;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_vld;
    logic              mirror_vert;

    int       n_run  = 0;
    int       n_fail = 0;
    bit       done   = 0;
    int       model [8];
    int       model_mir = 0;
    sb_item_t sb_q [$];

    always #5 clk = ~clk;

    nib_bank_mapper u_nib_bank_mapper (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .rom_addr(rom_addr),
        .rom_vld(rom_vld), .mirror_vert(mirror_vert)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_rom(input int a);
        int r;
        if (a >= 'hC000)      r = 7 * 'h4000 + (a % 'h4000);
        else if (a >= 'hA000) r = 13 * 'h2000 + (a % 'h2000);
        else                  r = model[(a - 'h6000) / 'h800] * 'h800 + (a % 'h800);
        return r & MASK;
    endfunction

    function automatic void model_write(input int a, input int d);
        int base;
        int idx;
        if (a >= 'hB000 && a <= 'hE003) begin
            case (a / 'h1000)
                'hB:     base = 4;
                'hC:     base = 6;
                'hD:     base = 0;
                default: base = 2;
            endcase
            idx = base + ((a >> 1) & 1);
            if (a % 2 == 1) model[idx] = (model[idx] & 'h0F) | ((d & 'hF) << 4);
            else            model[idx] = (model[idx] & 'hF0) | (d & 'hF);
        end
        if (a >= 'h8000 && a < 'hA000) model_mir = d & 1;
    endfunction

    // one active cycle, one idle cycle; returns at the negedge where results are visible
    task automatic bus(input int a, input int d, input bit rd, input bit wr, input string tag);
        sb_item_t it;
        @(negedge clk);
        cpu_addr = 16'(a);
        cpu_data = 8'(d);
        cpu_rd   = rd;
        cpu_wr   = wr;
        if (rd && a >= 'h6000) begin
            it.exp = exp_rom(a);
            it.tag = tag;
            sb_q.push_back(it);
        end
        if (wr) model_write(a, d);
        @(negedge clk);
        cpu_rd = 1'b0;
        cpu_wr = 1'b0;
    endtask

    task automatic wr(input int a, input int d);
        bus(a, d, 1'b0, 1'b1, "");
    endtask

    task automatic rd(input int a, input string tag);
        bus(a, 0, 1'b1, 1'b0, tag);
    endtask

    task automatic read_all_windows(input string tag);
        for (int k = 0; k < 8; k++) rd('h6000 + k * 'h800 + 'h155 + k, tag);
    endtask

    // monitor: pops expected translations as the design presents them
    always @(negedge clk) begin
        if (rst_n && rom_vld) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected rom_vld", 1, 0);
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(int'(rom_addr) == it.exp, it.tag, int'(rom_addr), it.exp);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int prev;
        for (int k = 0; k < 8; k++) model[k] = 0;
        repeat (3) @(negedge clk);
        check(rom_vld == 1'b0, "R1 rom_vld in reset", int'(rom_vld), 0);
        check(mirror_vert == 1'b0, "R1 mirror in reset", int'(mirror_vert), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rom_vld == 1'b0, "R1 rom_vld after reset", int'(rom_vld), 0);
        check(mirror_vert == 1'b0, "R1 mirror after reset", int'(mirror_vert), 0);
        read_all_windows("R1 R5 zero registers");

        // R4: one distinct value per register through its own address pair
        wr('hD000, 'h1); wr('hD001, 'h1);
        wr('hD002, 'h2); wr('hD003, 'h2);
        wr('hE000, 'h3); wr('hE001, 'h0);
        wr('hE002, 'h4); wr('hE003, 'h0);
        wr('hB000, 'h5); wr('hB001, 'h0);
        wr('hB002, 'h6); wr('hB003, 'h1);
        wr('hC000, 'h7); wr('hC001, 'h0);
        wr('hC002, 'h8); wr('hC003, 'h0);
        read_all_windows("R4 R5 register mapping");

        // R4 aliasing through address bits 11:2
        wr('hB7FC, 'h9);
        wr('hCAA5, 'h2);
        read_all_windows("R4 alias write");

        // R2 / R3 nibble retention, upper data bits ignored
        wr('hD001, 'hF3);
        rd('h6010, "R3 high nibble keeps low");
        wr('hD000, 'hEC);
        rd('h67FF, "R2 low nibble keeps high");

        // R6 / R7 fixed banks
        rd('hA000, "R6 fixed 8K start");
        rd('hBFFF, "R6 fixed 8K end");
        rd('hC000, "R7 fixed 16K start");
        rd('hE123, "R7 fixed 16K mid");
        rd('hFFFF, "R7 fixed 16K end");

        // R8 mirroring
        wr('h8000, 'h01);
        check(mirror_vert == 1'b1, "R8 mirror set vertical", int'(mirror_vert), 1);
        wr('h9FFF, 'hFE);
        check(mirror_vert == 1'b0, "R8 mirror set horizontal", int'(mirror_vert), 0);

        // R9 ignored writes
        wr('h6000, 'hFF);
        wr('hA003, 'hFF);
        wr('hE004, 'hFF);
        wr('hF000, 'hFF);
        wr('hFFFF, 'hFF);
        check(mirror_vert == 1'b0, "R9 mirror untouched", int'(mirror_vert), 0);
        read_all_windows("R9 registers untouched");

        // R10 reads below 0x6000
        rd('h7000, "R10 reference read");
        prev = int'(rom_addr);
        rd('h5FFF, "R10 low read");
        check(rom_vld == 1'b0, "R10 no pulse below 0x6000", int'(rom_vld), 0);
        check(int'(rom_addr) == prev, "R10 rom_addr held", int'(rom_addr), prev);
        rd('h0000, "R10 low read");
        check(rom_vld == 1'b0, "R10 no pulse at 0x0000", int'(rom_vld), 0);

        // R11 read and write in one cycle
        bus('h8800, 'h01, 1'b1, 1'b1, "R11 window read with mirror write");
        check(mirror_vert == 1'b1, "R11 mirror applied", int'(mirror_vert), 1);
        bus('hD003, 'h07, 1'b1, 1'b1, "R11 fixed read with register write");
        rd('h6800, "R11 register write applied");

        // R12 wrap to ROM size
        wr('hC002, 'hF); wr('hC003, 'hF);
        rd('h9FFF, "R12 wrap at top");
        rd('h9800, "R12 wrap base");

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "R10 all reads answered", sb_q.size(), 0);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule